// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a 16-bit up-counting timer that drives one PWM pin. One compare value sets the cycle length and a second sets how long the pin stays active in each cycle. The comparators never see the software-written values directly. Each compare value has a shadow buffer, and the comparators read only the buffers. New values reach the buffers only when the counter wraps, and only after software has written the duty value. Software can therefore change period and duty together with no glitch. To change only the period, software writes the period value and then writes the duty value again.

Software configures the block through a plain register write port. Every write is taken in the cycle it is presented, so the port has no back-pressure and no ready signal. The control word holds an enable bit and a 3-bit clock-select field k. The count advances once every 2^k system clocks. While counting is disabled, the counter rests at 0, the pin is inactive, and the buffers follow the written compare values. The first enabled cycle therefore uses the latest values without any arming write.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset the pin is low and the counter sits at 0 until counting is enabled.
- R2: While enabled, the counter steps 0,1,…,P and returns to 0 on the tick after it equals the buffered period P, so one cycle lasts P+1 ticks.
- R3: The pin is high exactly while the count is below the buffered duty D. D=0 keeps the pin low, and any D greater than P keeps it high.
- R4: A tick occurs once every 2^k system clocks. k is bits 3:1 of the control word (select 0), and k=0 gives a tick on every clock.
- R5: Bit 0 of the control word is the enable. The clock-select field may be written in the same access that sets it. On enable, the buffers already hold the last written compare values.
- R6: Writing only the period register (select 1) while running leaves the buffered period unchanged through any number of wraps.
- R7: A write to the duty register (select 2) arms a reload. At the next wrap, both buffers take the written period and duty together, and the reload then disarms.
- R8: A compare write made while running does not change the pin before the next wrap.
- R9: Clearing the enable bit forces the pin low and the counter to 0 from the next cycle. Re-enabling restarts the count from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 ignored |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output, active high |

## Verification
The bench changes the duty value mid-cycle and expects the old duty to hold until the wrap. A design that reloads straight away would cut the current pulse short. It writes the period alone and expects the old cycle length to persist. A design that arms on period writes, or that reloads on every wrap, would switch early. After a reload it writes the period again and expects nothing to change, which catches an arm flag that never clears. The bench also covers duty values of zero and above the period, a prescaled tick, and a disable followed by re-enable. These catch an off-by-one compare, a wrong divider mask, or a counter that resumes from its old value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_KSEL_LO = 1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int KSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [KSEL_W-1:0] ksel,
  output logic              tick
);
  localparam int DIV_W = (1 << KSEL_W) - 1;

  logic [DIV_W-1:0] divcnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (b < int'(ksel)) mask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       divcnt <= '0;
    else if (!run_en) divcnt <= '0;
    else              divcnt <= divcnt + 1'b1;
  end

  assign tick = run_en && ((divcnt & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ksel != '0) |=> (!tick || !$stable(ksel))); // R4
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap,
  output logic [CNT_W-1:0] per_buf,
  output logic [CNT_W-1:0] duty_buf
);
  logic [CNT_W-1:0] per_reg, duty_reg;
  logic             armed;
  logic             duty_wr;

  assign duty_wr = wr_en && (wr_sel == SEL_DUTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_reg  <= '0;
      duty_reg <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_PER)  per_reg  <= wr_data;
      if (wr_sel == SEL_DUTY) duty_reg <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
      armed    <= 1'b0;
    end else if (!run_en) begin
      per_buf  <= per_reg;
      duty_buf <= duty_reg;
      armed    <= 1'b0;
    end else if (wrap && armed) begin
      per_buf  <= per_reg;
      duty_buf <= duty_reg;
      armed    <= duty_wr;
    end else if (duty_wr) begin
      armed    <= 1'b1;
    end
  end

  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$past(wrap)) |-> $stable(per_buf)); // R6
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wrap && armed && !duty_wr) |=> !armed); // R7
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_buf,
  input  logic [CNT_W-1:0] duty_buf,
  output logic             wrap,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt;

  assign wrap = run_en && tick && (cnt == per_buf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run_en) cnt <= '0;
    else if (tick)    cnt <= (cnt == per_buf) ? '0 : cnt + 1'b1;
  end

  assign pwm_out = run_en && (cnt < duty_buf);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (cnt <= per_buf)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0)); // R9
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int KSEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);
  localparam int KSEL_HI = CTRL_KSEL_LO + KSEL_W - 1;

  logic              run_en;
  logic [KSEL_W-1:0] ksel;
  logic              tick, wrap;
  logic [CNT_W-1:0]  per_buf, duty_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      ksel   <= '0;
    end else if (wr_en && wr_sel == SEL_CTRL) begin
      run_en <= wr_data[CTRL_EN_BIT];
      ksel   <= wr_data[KSEL_HI:CTRL_KSEL_LO];
    end
  end

  pwm_prescaler #(.KSEL_W(KSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ksel(ksel), .tick(tick)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shd (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .wrap(wrap),
    .per_buf(per_buf), .duty_buf(duty_buf)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .per_buf(per_buf), .duty_buf(duty_buf), .wrap(wrap), .pwm_out(pwm_out)
  );

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL && !wr_data[CTRL_EN_BIT]) |=> !pwm_out); // R9
endmodule

// File: tb/sim_pwm_dbuf_timer.sv
module sim_pwm_dbuf_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwm_dbuf_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after the write lands
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // index i counts negedges since the enabling write took effect
  task automatic window(input int p, input int d, input int k,
                        input int start, input int n, input string tag);
    int miss = 0;
    int first = -1;
    for (int i = start; i < start + n; i++) begin
      int e = (((i >> k) % (p + 1)) < d) ? 1 : 0;
      if (int'(pwm_out) != e) begin
        miss++;
        if (first < 0) first = i;
      end
      @(negedge clk);
    end
    chk(miss, 0, $sformatf("%s mismatched samples (first at %0d)", tag, first));
  endtask

  task automatic t_reset();
    chk(int'(pwm_out), 0, "R1 pin after reset");
    repeat (5) @(negedge clk);
    chk(int'(pwm_out), 0, "R1 pin while disabled");
  endtask

  task automatic t_basic();
    wr(2'd1, 16'd9); wr(2'd2, 16'd3); wr(2'd0, 16'h0001);
    window(9, 3, 0, 0, 40, "R2 R3 basic P=9 D=3");
    wr(2'd0, 16'h0000);
    chk(int'(pwm_out), 0, "R9 pin low after disable");
  endtask

  task automatic t_prescale();
    wr(2'd1, 16'd4); wr(2'd2, 16'd2); wr(2'd0, 16'h0005);
    window(4, 2, 2, 0, 60, "R4 R5 k=2 set with enable");
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_extremes();
    wr(2'd1, 16'd5); wr(2'd2, 16'd0); wr(2'd0, 16'h0001);
    window(5, 0, 0, 0, 24, "R3 duty zero");
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd12); wr(2'd0, 16'h0001);
    window(5, 12, 0, 0, 24, "R3 duty above period");
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_reload();
    wr(2'd1, 16'd9); wr(2'd2, 16'd3); wr(2'd0, 16'h0001);
    window(9, 3, 0, 0, 4, "R2 pre-change");
    wr(2'd2, 16'd7);
    window(9, 3, 0, 5, 5, "R8 old duty until wrap");
    window(9, 7, 0, 10, 30, "R7 new duty after wrap");
    wr(2'd1, 16'd5);
    window(9, 7, 0, 41, 29, "R6 period write alone");
    wr(2'd2, 16'd2);
    window(9, 7, 0, 71, 9, "R8 armed, old values until wrap");
    window(5, 2, 0, 0, 24, "R7 period and duty reloaded together");
    wr(2'd1, 16'd9);
    window(5, 2, 0, 25, 18, "R7 arm cleared after reload");
  endtask

  task automatic t_restart();
    wr(2'd0, 16'h0000);
    chk(int'(pwm_out), 0, "R9 pin low after stop");
    repeat (3) @(negedge clk);
    chk(int'(pwm_out), 0, "R9 pin stays low while stopped");
    wr(2'd0, 16'h0001);
    window(9, 2, 0, 0, 30, "R5 R9 restart from zero, direct load");
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_extremes();
    t_reload();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule